// File: doc/BRIEF.md
# Multi-channel DAC control register block

This block is the write-side register file that steers a small bank of analog output converters. A host issues 16-bit writes over a simple strobed bus. One control register takes packed command words. These words switch individual output channels on or off, switch pattern mode on or off, and set the data-format and output-queue-clear flags. Each channel also has its own setting register, which holds the code to be converted. A reference register launches an update of the positive or the negative reference level.

The converters are not modelled as analog parts. Each one is a busy timer. A setting write makes the channel busy for a programmable number of clock cycles. A reference write makes the reference busy for its own programmable time. The host polls a status word at the control offset to learn when each update has finished. The last value written to each channel can be read back at that channel's setting offset. The enable state of each channel is also driven on a dedicated output.

Top module: `dac_ctrl_regs`

## Requirements
- R1: After reset, all channel enables, pattern mode, the signed flag, the queue-clear pulse and the reference select are 0. The status word and every readback read 0.
- R2: A control write (offset 0x20) of 0x0021 + (ch<<4) enables channel ch, and 0x0020 + (ch<<4) disables it. Other channels are unchanged. The channel is taken from bits 7:4 minus 2, and the on/off value from bit 0.
- R3: A control write of 0x0061 turns pattern mode on, and 0x0060 turns it off. Channel enables are unchanged.
- R4: A control write whose bits 7:4 and bit 3 are zero stores bit 1 (0x0002) as the signed-data flag. If bit 2 (0x0004) is set, the same write raises the output-queue-clear pulse for exactly one cycle, starting on the cycle after the write.
- R5: A write to offset 0x38 + 2*ch stores the 16-bit value for channel ch. Reading that offset returns the stored value.
- R6: A setting write for channel ch sets status bit 4+ch from the cycle after the write. The bit stays set for BUSY_CYCLES cycles and then clears.
- R7: A setting write to a channel that is still busy restarts its busy time from the full BUSY_CYCLES.
- R8: A write to offset 0x2C with bit 7 (0x0080) set makes status bit 1 (reference busy) set for REF_CYCLES cycles. The same write latches bit 8 (0x0100) as the reference select: 1 selects positive, 0 selects negative.
- R9: A reference write with bit 7 clear, a write to an odd or unmapped offset, a control word with an unused command field (bits 7:4 not 0, 2 to 5 or 6), and any cycle with the write strobe low all change no state.
- R10: Status bits 0 (queue full), 2 (trigger busy) and 3 (calibration busy) always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 16 | Write data |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 16 | Read data (status or readback), combinational |
| ch_enable | output | NUM_CH | Per-channel enable state |
| pattern_en | output | 1 | Pattern mode on |
| data_signed | output | 1 | Channel data is two's complement |
| fifo_reset | output | 1 | One-cycle output queue clear pulse |
| ref_sel_pos | output | 1 | Last launched reference update was positive |

## Verification
The checker runs on every cycle. It checks that a channel busy bit rises only after a setting write for that channel, and that every setting write and every launching reference write is followed by busy. It checks that enables and the reference select move only on a relevant write, and that the queue-clear pulse has a matching control write behind it. It also checks that the unused status bits stay low. Only the bench scenarios can show the exact busy length, the restart on a rewrite, the stored readback values, the walk through the command codes, and that odd offsets and unused codes leave all outputs unchanged.

// File: rtl/dacreg_pkg.sv
package dacreg_pkg;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 8;
    localparam int MAX_CH   = 4;

    localparam logic [ADDR_W-1:0] CTRL_OFS = 8'h20;
    localparam logic [ADDR_W-1:0] REF_OFS  = 8'h2C;
    localparam logic [ADDR_W-1:0] SET_BASE = 8'h38;

    localparam logic [3:0] FIELD_CONFIG  = 4'h0;
    localparam logic [3:0] FIELD_CH_BASE = 4'h2;
    localparam logic [3:0] FIELD_PATTERN = 4'h6;

    localparam int REF_LAUNCH_BIT = 7;
    localparam int REF_POS_BIT    = 8;
    localparam int STAT_REF_BUSY  = 1;
    localparam int STAT_CH_BASE   = 4;

    typedef struct packed {
        logic [3:0] field;
        logic [3:0] low;
    } ctrl_word_t;

    function automatic logic [ADDR_W-1:0] setting_addr(input int ch);
        return SET_BASE + ADDR_W'(2 * ch);
    endfunction
endpackage

// File: rtl/dac_busy_timer.sv
module dac_busy_timer #(
    parameter int LOAD  = 5,
    parameter int CNT_W = $clog2(LOAD + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(LOAD);

    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (start)
            remain <= LOAD_V;
        else if (remain != '0)
            remain <= remain - 1'b1;
    end

    assign busy = (remain != '0);
endmodule

// File: rtl/dac_ctrl_decode.sv
module dac_ctrl_decode
    import dacreg_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [7:0]        cmd,
    output logic [NUM_CH-1:0] ch_enable,
    output logic              pattern_en,
    output logic              data_signed,
    output logic              fifo_reset
);
    ctrl_word_t w;
    assign w = ctrl_word_t'(cmd);

    always_ff @(posedge clk) begin
        if (rst) begin
            ch_enable   <= '0;
            pattern_en  <= 1'b0;
            data_signed <= 1'b0;
            fifo_reset  <= 1'b0;
        end else begin
            fifo_reset <= 1'b0;
            if (we) begin
                if (w.field == FIELD_CONFIG) begin
                    if (!w.low[3]) begin
                        data_signed <= w.low[1];
                        fifo_reset  <= w.low[2];
                    end
                end else if (w.field == FIELD_PATTERN) begin
                    pattern_en <= w.low[0];
                end else begin
                    for (int c = 0; c < NUM_CH; c++)
                        if (w.field == FIELD_CH_BASE + 4'(c))
                            ch_enable[c] <= w.low[0];
                end
            end
        end
    end
endmodule

// File: rtl/dac_ctrl_regs.sv
module dac_ctrl_regs
    import dacreg_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int BUSY_CYCLES = 5,
    parameter int REF_CYCLES  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [15:0]       wr_data,
    input  logic [7:0]        rd_addr,
    output logic [15:0]       rd_data,
    output logic [NUM_CH-1:0] ch_enable,
    output logic              pattern_en,
    output logic              data_signed,
    output logic              fifo_reset,
    output logic              ref_sel_pos
);
    // Command field 6 is pattern mode, so at most MAX_CH channel codes exist.
    localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);
    localparam int REF_W  = $clog2(REF_CYCLES + 1);

    logic [NUM_CH-1:0] set_hit;
    logic [NUM_CH-1:0] ch_busy;
    logic              ref_start;
    logic              ref_busy;
    logic [DATA_W-1:0] readback [NUM_CH];
    logic [DATA_W-1:0] status;

    dac_ctrl_decode #(.NUM_CH(NUM_CH)) u_decode (
        .clk         (clk),
        .rst         (rst),
        .we          (wr_en && wr_addr == CTRL_OFS),
        .cmd         (wr_data[7:0]),
        .ch_enable   (ch_enable),
        .pattern_en  (pattern_en),
        .data_signed (data_signed),
        .fifo_reset  (fifo_reset)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            assign set_hit[c] = wr_en && (wr_addr == setting_addr(c));

            dac_busy_timer #(.LOAD(BUSY_CYCLES), .CNT_W(BUSY_W)) u_timer (
                .clk   (clk),
                .rst   (rst),
                .start (set_hit[c]),
                .busy  (ch_busy[c])
            );

            always_ff @(posedge clk) begin
                if (rst)
                    readback[c] <= '0;
                else if (set_hit[c])
                    readback[c] <= wr_data;
            end
        end
    endgenerate

    assign ref_start = wr_en && (wr_addr == REF_OFS) && wr_data[REF_LAUNCH_BIT];

    dac_busy_timer #(.LOAD(REF_CYCLES), .CNT_W(REF_W)) u_ref_timer (
        .clk   (clk),
        .rst   (rst),
        .start (ref_start),
        .busy  (ref_busy)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ref_sel_pos <= 1'b0;
        else if (ref_start)
            ref_sel_pos <= wr_data[REF_POS_BIT];
    end

    always_comb begin
        status = '0;
        status[STAT_REF_BUSY] = ref_busy;
        for (int c = 0; c < NUM_CH; c++)
            status[STAT_CH_BASE + c] = ch_busy[c];
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == CTRL_OFS)
            rd_data = status;
        for (int c = 0; c < NUM_CH; c++)
            if (rd_addr == setting_addr(c))
                rd_data = readback[c];
    end
endmodule

// File: rtl/dac_ctrl_regs_chk.sv
module dac_ctrl_regs_chk
    import dacreg_pkg::*;
#(
    parameter int NUM_CH = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [7:0]        wr_addr,
    input logic [15:0]       wr_data,
    input logic [7:0]        rd_addr,
    input logic [15:0]       rd_data,
    input logic [NUM_CH-1:0] ch_enable,
    input logic              fifo_reset,
    input logic              ref_sel_pos,
    input logic [NUM_CH-1:0] ch_busy,
    input logic              ref_busy
);
    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
            // R6: a setting write is always followed by busy
            a_r6_busy_after_write: assert property (@(posedge clk) disable iff (rst)
                (wr_en && wr_addr == setting_addr(c)) |=> ch_busy[c]);
            // R6: busy only starts from a setting write of this channel
            a_r6_busy_rise_cause: assert property (@(posedge clk) disable iff (rst)
                $rose(ch_busy[c]) |-> $past(wr_en && wr_addr == setting_addr(c)));
        end
    endgenerate

    a_r2_enable_needs_write: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_addr == CTRL_OFS) |=> $stable(ch_enable));

    a_r4_clear_pulse_cause: assert property (@(posedge clk) disable iff (rst)
        fifo_reset |-> $past(wr_en && wr_addr == CTRL_OFS && wr_data[2]));

    a_r8_ref_busy_start: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == REF_OFS && wr_data[REF_LAUNCH_BIT]) |=> ref_busy);

    a_r9_ref_sel_hold: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_addr == REF_OFS && wr_data[REF_LAUNCH_BIT]) |=> $stable(ref_sel_pos));

    always_comb begin
        if (!rst && rd_addr == CTRL_OFS)
            a_r10_idle_flags: assert (rd_data[3:2] == 2'b00 && rd_data[0] == 1'b0);
    end
endmodule

bind dac_ctrl_regs dac_ctrl_regs_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .ch_enable  (ch_enable),
    .fifo_reset (fifo_reset),
    .ref_sel_pos(ref_sel_pos),
    .ch_busy    (ch_busy),
    .ref_busy   (ref_busy)
);

// File: tb/test_dac_ctrl_regs.sv
module test_dac_ctrl_regs;
    localparam int NUM_CH = 4;
    localparam int BUSY   = 5;
    localparam int REFC   = 3;
    localparam int NVEC   = 10;

    // {command word, expected enables, expected pattern}
    localparam logic [20:0] VEC [NVEC] = '{
        {16'h0021, 4'b0001, 1'b0},
        {16'h0051, 4'b1001, 1'b0},
        {16'h0031, 4'b1011, 1'b0},
        {16'h0061, 4'b1011, 1'b1},
        {16'h0020, 4'b1010, 1'b1},
        {16'h0071, 4'b1010, 1'b1},
        {16'h0060, 4'b1010, 1'b0},
        {16'h0041, 4'b1110, 1'b0},
        {16'h0050, 4'b0110, 1'b0},
        {16'h0023, 4'b0111, 1'b0}
    };

    logic clk = 0, rst = 1, wr_en = 0;
    logic [7:0] wr_addr = 0, rd_addr = 8'h20;
    logic [15:0] wr_data = 0, rd_data;
    logic [NUM_CH-1:0] ch_enable;
    logic pattern_en, data_signed, fifo_reset, ref_sel_pos;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dac_ctrl_regs #(.NUM_CH(NUM_CH), .BUSY_CYCLES(BUSY), .REF_CYCLES(REFC)) i_dac_ctrl_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ch_enable(ch_enable),
        .pattern_en(pattern_en), .data_signed(data_signed),
        .fifo_reset(fifo_reset), .ref_sel_pos(ref_sel_pos)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        rd_addr = a; #1; d = rd_data; rd_addr = 8'h20;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [15:0] v;
        idle(3); rst = 0; idle(1);
        // R1 reset state
        chk("R1 enables", ch_enable, 0);
        chk("R1 flags", {pattern_en, data_signed, fifo_reset, ref_sel_pos}, 0);
        rd(8'h20, v); chk("R1 status", v, 0);
        rd(8'h3A, v); chk("R1 readback", v, 0);

        // R2 / R3 command walk
        for (int i = 0; i < NVEC; i++) begin
            wr(8'h20, VEC[i][20:5]);
            chk($sformatf("R2 enables vec%0d", i), ch_enable, VEC[i][4:1]);
            chk($sformatf("R3 pattern vec%0d", i), pattern_en, VEC[i][0]);
        end

        // R4 config word
        wr(8'h20, 16'h0006);
        chk("R4 signed set", data_signed, 1);
        chk("R4 pulse high", fifo_reset, 1);
        idle(1);
        chk("R4 pulse one cycle", fifo_reset, 0);
        wr(8'h20, 16'h0000);
        chk("R4 signed clear", data_signed, 0);
        chk("R4 no pulse", fifo_reset, 0);
        wr(8'h20, 16'h000E);
        chk("R9 bit3 config ignored", {data_signed, fifo_reset}, 0);

        // R5 readback
        for (int c = 0; c < NUM_CH; c++) wr(8'h38 + 8'(2*c), 16'hA100 + 16'(c));
        idle(BUSY + 1);
        for (int c = 0; c < NUM_CH; c++) begin
            rd(8'h38 + 8'(2*c), v);
            chk($sformatf("R5 readback ch%0d", c), v, 16'hA100 + 16'(c));
        end

        // R9 odd offset and unmapped offset
        wr(8'h39, 16'hFFFF);
        wr(8'h3F, 16'hFFFF);
        rd(8'h20, v); chk("R9 odd offset no busy", v, 0);
        rd(8'h38, v); chk("R9 odd offset readback", v, 16'hA100);
        chk("R9 state unchanged", {ch_enable, pattern_en}, {4'b0111, 1'b0});

        // R6 busy timing, channel 2
        wr(8'h3C, 16'h1234);
        rd(8'h20, v); chk("R6 busy first cycle", v, 16'h0040);
        idle(BUSY - 1);
        rd(8'h20, v); chk("R6 busy last cycle", v, 16'h0040);
        idle(1);
        rd(8'h20, v); chk("R6 busy cleared", v, 0);

        // R7 restart on rewrite, channel 3
        wr(8'h3E, 16'h0001);
        idle(2);
        wr(8'h3E, 16'h0002);
        idle(BUSY - 1);
        rd(8'h20, v); chk("R7 restart still busy", v, 16'h0080);
        idle(1);
        rd(8'h20, v); chk("R7 restart cleared", v, 0);
        rd(8'h3E, v); chk("R7 latest value", v, 16'h0002);

        // R8 reference updates
        wr(8'h2C, 16'h0180);
        rd(8'h20, v); chk("R8 ref busy", v, 16'h0002);
        chk("R8 positive select", ref_sel_pos, 1);
        idle(REFC - 1);
        rd(8'h20, v); chk("R8 ref busy last", v, 16'h0002);
        idle(1);
        rd(8'h20, v); chk("R8 ref done", v, 0);
        wr(8'h2C, 16'h0080);
        chk("R8 negative select", ref_sel_pos, 0);
        idle(REFC);
        // R9 no launch bit
        wr(8'h2C, 16'h0100);
        rd(8'h20, v); chk("R9 ref no launch", v, 0);
        chk("R9 ref select kept", ref_sel_pos, 0);

        // R10 unused status flags while everything is busy
        for (int c = 0; c < NUM_CH; c++) wr(8'h38 + 8'(2*c), 16'h0);
        wr(8'h2C, 16'h0080);
        rd(8'h20, v); chk("R10 unused bits zero", {v[3:2], v[0]}, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule